// File: doc/BRIEF.md
# Skewed Instruction Broadcast Network

This block hands one broadcast instruction stream to every processing element (PE) of a linear SIMD array, and gives each PE its own arrival time. Each PE after PE0 has a one-cycle register, fed by the tap of the PE before it, and a two-way selector. The selector either takes that register's output or takes the bus word directly. A per-array distance setting, `k`, restarts the delay chain every `k` PEs. PE n therefore sees each instruction `n mod k` cycles after it appears on the bus. PE0 always takes the bus directly. The instruction order is the same at every PE. Only the arrival time differs.

The bus side is a stream with a valid bit and no ready. PEs execute every slot in lockstep, so the network never applies back-pressure: a word presented with `bus_valid` high is accepted in that cycle. A slot with `bus_valid` low is an idle slot and reaches every PE as a NOP, with valid low. The distance setting should change only while the bus is idle. After a change, `cfg_ready` drops and then rises again once enough idle cycles have cleared every path that the new setting uses.

Top module: `skew_bcast_top`

## Requirements
- R1: PE0's tap (`pe_valid[0]`, `pe_instr` bits `[INSTR_W-1:0]`) equals the bus in the same cycle, with no register in between.
- R2: For a registered distance k with 1 <= k <= NUM_PE, PE n shows the bus slot from `n mod k` cycles earlier. The registered distance is `cfg_k` as sampled on the most recent rising clock edge. PE n's word occupies `pe_instr[n*INSTR_W +: INSTR_W]`.
- R3: A distance value of 0 is treated as 1: every PE shows the current bus slot.
- R4: A distance of NUM_PE or more gives the full chain, in which PE n shows the slot from n cycles earlier.
- R5: The valid bit travels with its word through the same registers and selectors. An idle bus slot appears at each PE as valid low, at that PE's delay. The word field carries no meaning while valid is low.
- R6: A synchronous reset (`rst` high at a rising edge) clears every delay register to valid low. It also sets `cfg_ready` high and registers the current `cfg_k`. After reset, with an idle bus, all `pe_valid` bits are low.
- R7: Let D = min(max(k,1), NUM_PE) - 1 for a newly sampled distance k. If D > 0, `cfg_ready` is low after the edge that samples the change. It rises after D consecutive later edges with `bus_valid` low. An edge with `bus_valid` high during this wait restarts the count.
- R8: A change to a distance whose D is 0 (k of 0 or 1) leaves `cfg_ready` high.
- R9: While `cfg_k` stays unchanged, `cfg_ready` stays high whatever the bus traffic is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Broadcast slot carries an instruction |
| bus_instr | input | INSTR_W | Broadcast instruction word |
| cfg_k | input | K_W | Maximum neighbour distance; chain restarts every k PEs |
| cfg_ready | output | 1 | High when all paths reflect the registered distance |
| pe_valid | output | NUM_PE | Per-PE valid, bit n for PE n |
| pe_instr | output | NUM_PE*INSTR_W | Per-PE instruction words, PE n at bits n*INSTR_W upward |

## Verification
The bench targets these corners:
- The wrap point of the modulo skew. Off-by-one phase logic would hand a PE at a multiple of k a delayed word instead of the live bus word.
- The two degenerate distances, 0 and any value at or beyond NUM_PE. A design that divides by the raw value, or that wraps the chain at NUM_PE, would skew the wrong PEs.
- Idle gaps inside bursts. If the valid bit did not follow the word, a repeated instruction would show up where a NOP belongs.
- The flush after a distance change. It includes a valid slot that arrives mid-flush, and a change to k = 1. A tracker that miscounts would raise `cfg_ready` while a stale register is still visible, or would drop it when no flush is needed.

// File: rtl/skew_bcast_pkg.sv
package skew_bcast_pkg;

  // Distance 0 behaves as distance 1.
  function automatic int unsigned sb_eff_dist(input int unsigned k);
    return (k == 0) ? 1 : k;
  endfunction

  // Number of idle cycles needed before every used path is fresh.
  function automatic int unsigned sb_flush_len(input int unsigned k, input int unsigned n_pe);
    int unsigned ke;
    ke = sb_eff_dist(k);
    if (ke > n_pe) ke = n_pe;
    return ke - 1;
  endfunction

endpackage

// File: rtl/skew_tap_select.sv
// Derives each stage's selector setting from the registered distance by
// walking a phase counter along the array.
module skew_tap_select #(
  parameter int NUM_PE = 8,
  parameter int K_W    = $clog2(NUM_PE + 1)
) (
  input  logic [K_W-1:0]    dist_q,
  output logic [NUM_PE-1:0] take_bus
);
  localparam int PH_W = K_W + 1;

  logic [PH_W-1:0] dist_eff;
  logic [PH_W-1:0] phase [NUM_PE];

  assign dist_eff = (dist_q == '0) ? PH_W'(1) : {1'b0, dist_q};
  assign phase[0] = '0;
  assign take_bus[0] = 1'b1;

  genvar n;
  generate
    for (n = 1; n < NUM_PE; n++) begin : g_phase
      logic [PH_W-1:0] step;
      assign step        = phase[n-1] + PH_W'(1);
      assign phase[n]    = (step >= dist_eff) ? '0 : step;
      assign take_bus[n] = (phase[n] == '0);
    end
  endgenerate

endmodule

// File: rtl/skew_stage.sv
// One array position after PE0: a delay register plus a bypass selector.
module skew_stage #(
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_bus,
  input  logic               bus_v,
  input  logic [INSTR_W-1:0] bus_w,
  input  logic               prev_v,
  input  logic [INSTR_W-1:0] prev_w,
  output logic               tap_v,
  output logic [INSTR_W-1:0] tap_w
);
  logic               hold_v;
  logic [INSTR_W-1:0] hold_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v <= 1'b0;
      hold_w <= '0;
    end else begin
      hold_v <= prev_v;
      hold_w <= prev_w;
    end
  end

  always_comb begin
    if (take_bus) begin
      tap_v = bus_v;
      tap_w = bus_w;
    end else begin
      tap_v = hold_v;
      tap_w = hold_w;
    end
  end

endmodule

// File: rtl/skew_flush_track.sv
// Registers the distance setting and tracks the idle cycles needed to clear
// the chain after it changes.
module skew_flush_track #(
  parameter int NUM_PE = 8,
  parameter int K_W    = $clog2(NUM_PE + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [K_W-1:0] cfg_k,
  input  logic           bus_valid,
  output logic [K_W-1:0] dist_q,
  output logic           ready
);
  import skew_bcast_pkg::*;

  localparam int C_W = K_W + 1;

  logic [C_W-1:0] idle_cnt;
  logic [C_W-1:0] need_new;
  logic [C_W-1:0] need_cur;
  logic           ready_q;
  logic           changed;

  assign need_new = C_W'(sb_flush_len(int'(cfg_k), NUM_PE));
  assign need_cur = C_W'(sb_flush_len(int'(dist_q), NUM_PE));
  assign changed  = (cfg_k != dist_q);
  assign ready    = ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dist_q   <= cfg_k;
      idle_cnt <= '0;
      ready_q  <= 1'b1;
    end else if (changed) begin
      dist_q   <= cfg_k;
      idle_cnt <= '0;
      ready_q  <= (need_new == '0);
    end else if (!ready_q) begin
      if (bus_valid) begin
        idle_cnt <= '0;
      end else begin
        idle_cnt <= idle_cnt + C_W'(1);
        if (idle_cnt + C_W'(1) == need_cur) ready_q <= 1'b1;
      end
    end
  end

  // R7: a change needing a flush drops ready on the next cycle
  assert_drop_on_change_R7: assert property (@(posedge clk) disable iff (rst)
    (changed && need_new != '0) |=> !ready);

  // R7: the idle count never reaches the flush length while still waiting
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (idle_cnt < need_cur));

  // R9: ready holds while the setting is unchanged
  assert_hold_ready_R9: assert property (@(posedge clk) disable iff (rst)
    (ready && !changed) |=> ready);

  // R6: ready is high right after reset
  assert_ready_after_reset_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ready);

endmodule

// File: rtl/skew_bcast_top.sv
module skew_bcast_top #(
  parameter int NUM_PE  = 8,
  parameter int INSTR_W = 16,
  parameter int K_W     = $clog2(NUM_PE + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_valid,
  input  logic [INSTR_W-1:0]          bus_instr,
  input  logic [K_W-1:0]              cfg_k,
  output logic                        cfg_ready,
  output logic [NUM_PE-1:0]           pe_valid,
  output logic [NUM_PE*INSTR_W-1:0]   pe_instr
);
  logic [K_W-1:0]    dist_q;
  logic [NUM_PE-1:0] take_bus;
  logic              tap_v [NUM_PE];
  logic [INSTR_W-1:0] tap_w [NUM_PE];

  skew_flush_track #(.NUM_PE(NUM_PE), .K_W(K_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .cfg_k     (cfg_k),
    .bus_valid (bus_valid),
    .dist_q    (dist_q),
    .ready     (cfg_ready)
  );

  skew_tap_select #(.NUM_PE(NUM_PE), .K_W(K_W)) u_sel (
    .dist_q   (dist_q),
    .take_bus (take_bus)
  );

  // PE0 has neither register nor selector.
  assign tap_v[0] = bus_valid;
  assign tap_w[0] = bus_instr;

  genvar n;
  generate
    for (n = 1; n < NUM_PE; n++) begin : g_stage
      skew_stage #(.INSTR_W(INSTR_W)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .take_bus (take_bus[n]),
        .bus_v    (bus_valid),
        .bus_w    (bus_instr),
        .prev_v   (tap_v[n-1]),
        .prev_w   (tap_w[n-1]),
        .tap_v    (tap_v[n]),
        .tap_w    (tap_w[n])
      );

      // R5: a delayed tap carries the previous tap's valid from one cycle back
      assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst || !cfg_ready)
        !take_bus[n] |-> (tap_v[n] == $past(tap_v[n-1])));
    end

    for (n = 0; n < NUM_PE; n++) begin : g_out
      assign pe_valid[n]                   = tap_v[n];
      assign pe_instr[n*INSTR_W +: INSTR_W] = tap_w[n];
    end
  endgenerate

  // R6: after reset, an idle bus gives NOPs at every PE
  assert_reset_nop_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !bus_valid) |-> (pe_valid == '0));

  // R1: PE0 always follows the bus
  assert_pe0_live_R1: assert property (@(posedge clk) disable iff (rst)
    pe_valid[0] == bus_valid);

endmodule

// File: tb/skew_bcast_tb.sv
module skew_bcast_top_tb_top;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int W     = 16;
  localparam int KW    = $clog2(N + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_valid = 1'b0;
  logic [W-1:0]    bus_instr = '0;
  logic [KW-1:0]   cfg_k = KW'(4);
  logic            cfg_ready;
  logic [N-1:0]    pe_valid;
  logic [N*W-1:0]  pe_instr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state
  logic [W:0] hist [N];      // hist[d] = bus slot d edges ago, valid at bit W
  int  m_k     = 4;
  int  m_cnt   = 0;
  bit  m_ready = 1;
  bit  first_after_rst = 0;
  int  seed_v  = 12345;

  always #(CLK_P/2) clk = ~clk;

  skew_bcast_top #(.NUM_PE(N), .INSTR_W(W)) dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_instr(bus_instr),
    .cfg_k(cfg_k), .cfg_ready(cfg_ready), .pe_valid(pe_valid), .pe_instr(pe_instr)
  );

  function automatic int flush_len(input int k);
    int ke;
    ke = (k == 0) ? 1 : k;
    if (ke > N) ke = N;
    return ke - 1;
  endfunction

  function automatic string req_of(input int n, input int k);
    if (first_after_rst) return "R6";
    if (n == 0) return "R1";
    if (k == 0) return "R3";
    if (k >= N) return "R4";
    return "R2";
  endfunction

  task automatic compare();
    int ke;
    ke = (m_k == 0) ? 1 : m_k;
    checks++;
    if (cfg_ready !== m_ready) begin
      fails++;
      $display("FAIL %s cfg_ready k=%0d: actual %0b expected %0b",
               first_after_rst ? "R6" : "R7/R8/R9", m_k, cfg_ready, m_ready);
    end
    if (!m_ready) return;
    for (int n = 0; n < N; n++) begin
      int d;
      logic [W:0] e;
      d = n % ke;
      e = hist[d];
      checks++;
      if (pe_valid[n] !== e[W]) begin
        fails++;
        $display("FAIL R5/%s valid PE%0d k=%0d: actual %0b expected %0b",
                 req_of(n, m_k), n, m_k, pe_valid[n], e[W]);
      end
      if (e[W]) begin
        checks++;
        if (pe_instr[n*W +: W] !== e[W-1:0]) begin
          fails++;
          $display("FAIL %s word PE%0d k=%0d: actual %h expected %h",
                   req_of(n, m_k), n, m_k, pe_instr[n*W +: W], e[W-1:0]);
        end
      end
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      for (int i = 0; i < N; i++) hist[i] = '0;
      m_k = int'(cfg_k); m_cnt = 0; m_ready = 1;
      return;
    end
    for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
    if (int'(cfg_k) != m_k) begin
      m_k = int'(cfg_k); m_cnt = 0; m_ready = (flush_len(m_k) == 0);
    end else if (!m_ready) begin
      if (bus_valid) m_cnt = 0;
      else begin
        m_cnt++;
        if (m_cnt == flush_len(m_k)) m_ready = 1;
      end
    end
  endtask

  // one bus slot: drive after the falling edge, check, then account for the rising edge
  task automatic slot(input logic v, input logic [W-1:0] w, input int k);
    @(negedge clk);
    bus_valid = v; bus_instr = w; cfg_k = KW'(k);
    #1;
    hist[0] = {v, w};
    if (!rst) compare();
    first_after_rst = 0;
    model_edge();
  endtask

  task automatic burst(input int k, input int len, input int gap_mod);
    for (int i = 0; i < len; i++) begin
      logic v;
      seed_v = seed_v * 1103515245 + 12345;
      v = (gap_mod == 0) ? 1'b1 : ((seed_v >>> 16) % gap_mod != 0);
      slot(v, W'(seed_v >>> 8), k);
    end
  endtask

  task automatic settle(input int k);
    for (int i = 0; i < 20 && !(m_ready && m_k == k); i++) slot(1'b0, W'(16'hdead), k);
    slot(1'b0, '0, k);
  endtask

  initial begin
    for (int i = 0; i < N; i++) hist[i] = '0;
    rst = 1;
    for (int i = 0; i < 3; i++) slot(1'b0, '0, 4);
    @(negedge clk); rst = 0;
    first_after_rst = 1;                         // R6: reset state
    hist[0] = '0;
    #1; compare(); first_after_rst = 0; model_edge();

    burst(4, 40, 3);                             // R1 R2 R5: k=4 with gaps
    burst(4, 12, 0);                             // R2: back-to-back
    settle(3); burst(3, 30, 4);                  // R7 then R2 at k=3
    settle(0); burst(0, 20, 3);                  // R3: zero distance
    settle(8); burst(8, 30, 3);                  // R4: full chain at k=N
    settle(12); burst(12, 25, 2);                // R4: beyond N
    slot(1'b0, '0, 1); burst(1, 10, 3);          // R8: ready stays high
    // R7: valid slot during the flush restarts the count
    slot(1'b0, '0, 5); slot(1'b0, '0, 5); slot(1'b1, W'(16'h5a5a), 5);
    settle(5); burst(5, 30, 3);
    burst(5, 30, 0);                             // R9: ready held under full traffic
    settle(2); burst(2, 20, 5);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule